// File: doc/BRIEF.md
# Flash program status responder

This block models the device side of a small NOR-style flash array that is run by a one-cycle command port. A read returns stored words while the array is idle. Program and erase start an embedded operation that lasts several cycles. While that operation runs, a read returns a status word instead of array data. Programming can only clear bits. An erase sets every word back to all ones.

A program that asks for a 1 in a bit that already holds 0 can never complete. The array stays busy and the toggle bit keeps changing on every status read. The timeout bit is set only after a fixed number of cycles has passed. From then on, status reads show the timeout bit together with the toggle bit until a reset command returns the array to read mode. Command encoding on `cmd_op`: 2'b00 read, 2'b01 program, 2'b10 erase, 2'b11 reset.

Top module: `flash_status_resp`

## Requirements
- R1: After reset every word reads as all ones. An erase holds `busy` high for ERASE_CYC cycles and afterwards every word reads as all ones.
- R2: A program whose data has no 1 where the stored word has a 0 holds `busy` high for PROG_CYC cycles. The stored word then becomes the old word ANDed with the data.
- R3: A read while busy returns a status word in which bit 7 is the complement of bit 7 of the program data (0 during erase), bit 6 is the toggle bit, bit 5 is the timeout bit and all other bits are 0. The first status read after an operation starts has bit 6 = 1.
- R4: Every status read inverts bit 6 compared with the status read before it, before and after a timeout.
- R5: A program that asks for a 1 where the stored word holds 0 never finishes. The timeout bit reads 0 until TIMEOUT_CYC cycles after the start and reads 1 after that. `busy` stays high and the stored word is not changed.
- R6: A reset command is accepted in any state. `busy` is low on the next cycle, the array is back in read mode, and an aborted program leaves its word unchanged.
- R7: Program and erase commands that arrive while busy are ignored.
- R8: A read while idle returns the word at `cmd_addr` on `rd_data` one cycle after the command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cmd_valid | input | 1 | Command strobe, one cycle per command |
| cmd_op | input | 2 | Command code |
| cmd_addr | input | ADDR_W | Word address |
| cmd_data | input | DATA_W | Program data |
| rd_data | output | DATA_W | Array word or status word from the last read |
| busy | output | 1 | An embedded operation is running or has failed |

## Verification
The main target is a program that tries to raise a cleared bit. The bench reads status well before the cycle limit and then after it. A design that reports the timeout at once, or never, fails one of those reads. A design that lets the program finish or writes the word fails the read after the reset. The bench tracks the toggle bit across every status read and across the point where the timeout bit sets, so a toggle that stalls or restarts is caught. It also sends commands while an operation runs and aborts a legal program with a reset, which catches a design that queues commands or commits partial writes.

// File: rtl/flash_status_resp.sv
module flash_status_resp #(
  parameter int ADDR_W      = 3,
  parameter int DATA_W      = 8,
  parameter int PROG_CYC    = 6,
  parameter int ERASE_CYC   = 10,
  parameter int TIMEOUT_CYC = 40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [1:0]        cmd_op,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [DATA_W-1:0] cmd_data,
  output logic [DATA_W-1:0] rd_data,
  output logic              busy
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int CNT_W = $clog2(TIMEOUT_CYC + 1);
  localparam logic [1:0] OP_READ = 2'b00, OP_PROG = 2'b01, OP_ERASE = 2'b10, OP_RST = 2'b11;

  typedef enum logic [1:0] {S_IDLE, S_PROG, S_ERASE, S_FAIL} state_t;

  state_t            state;
  logic [DATA_W-1:0] mem [DEPTH];
  logic [CNT_W-1:0]  cnt;
  logic [ADDR_W-1:0] op_addr;
  logic [DATA_W-1:0] op_data;
  logic              doomed, tog, to_flag;
  logic [DATA_W-1:0] stat;

  wire idle      = (state == S_IDLE);
  wire rd_req    = cmd_valid && cmd_op == OP_READ;
  wire rst_req   = cmd_valid && cmd_op == OP_RST;
  wire start_pg  = cmd_valid && cmd_op == OP_PROG && idle;
  wire start_er  = cmd_valid && cmd_op == OP_ERASE && idle;
  wire running   = (state == S_PROG) || (state == S_ERASE);
  wire done      = (state == S_PROG && !doomed && cnt == CNT_W'(PROG_CYC - 1)) ||
                   (state == S_ERASE && cnt == CNT_W'(ERASE_CYC - 1));
  wire limit_hit = running && !done && cnt == CNT_W'(TIMEOUT_CYC - 1);

  assign busy = !idle;

  always_comb begin
    stat    = '0;
    stat[7] = ~op_data[7];
    stat[6] = tog;
    stat[5] = to_flag;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      cnt     <= '0;
      op_addr <= '0;
      op_data <= '1;
      doomed  <= 1'b0;
      to_flag <= 1'b0;
    end else if (rst_req) begin
      state   <= S_IDLE;
      cnt     <= '0;
      to_flag <= 1'b0;
    end else if (start_pg) begin
      state   <= S_PROG;
      cnt     <= '0;
      op_addr <= cmd_addr;
      op_data <= cmd_data;
      doomed  <= |(cmd_data & ~mem[cmd_addr]);
      to_flag <= 1'b0;
    end else if (start_er) begin
      state   <= S_ERASE;
      cnt     <= '0;
      op_data <= '1;
      doomed  <= 1'b0;
      to_flag <= 1'b0;
    end else if (done) begin
      state <= S_IDLE;
      cnt   <= '0;
    end else if (limit_hit) begin
      state   <= S_FAIL;
      to_flag <= 1'b1;
    end else if (running) begin
      cnt <= cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
    end else if (done && state == S_PROG) begin
      mem[op_addr] <= mem[op_addr] & op_data;
    end else if (done && state == S_ERASE) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data <= '0;
      tog     <= 1'b1;
    end else if (start_pg || start_er) begin
      tog <= 1'b1;
    end else if (rd_req) begin
      if (idle) begin
        rd_data <= mem[cmd_addr];
      end else begin
        rd_data <= stat;
        tog     <= ~tog;
      end
    end
  end

  // R5
  timeout_needs_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    to_flag |-> busy);

  // R5
  timeout_clear_on_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_pg || start_er) |=> !to_flag);

  // R4
  toggle_flips_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && rd_req) ##1 (busy && rd_req && !rst_req) |=> rd_data[6] != $past(rd_data[6]));

  // R6
  reset_to_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> !busy);

  // R1
  erase_fills_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && state == S_ERASE) |=> (mem[0] == '1 && !busy));

  // R7
  busy_cmd_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cmd_valid && (cmd_op == OP_PROG || cmd_op == OP_ERASE)) |=> $stable(op_addr) && $stable(op_data));
endmodule

// File: tb/flash_status_resp_bench.sv
module flash_status_resp_bench;
  localparam int PC = 6, EC = 10, TC = 40;
  logic clk = 0, rst_n = 0, cmd_valid = 0;
  logic [1:0] cmd_op = 0;
  logic [2:0] cmd_addr = 0;
  logic [7:0] cmd_data = 0, rd_data;
  logic busy;
  int checks = 0, errors = 0;
  bit exp_tog;
  bit finished = 0;

  always #10 clk = ~clk;

  flash_status_resp #(.ADDR_W(3), .DATA_W(8), .PROG_CYC(PC), .ERASE_CYC(EC), .TIMEOUT_CYC(TC))
    u_flash_status_resp (.clk, .rst_n, .cmd_valid, .cmd_op, .cmd_addr, .cmd_data, .rd_data, .busy);

  task automatic check(string req, logic [7:0] got, logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic cmd(logic [1:0] op, logic [2:0] a, logic [7:0] d);
    @(negedge clk);
    cmd_valid = 1; cmd_op = op; cmd_addr = a; cmd_data = d;
    @(negedge clk);
    cmd_valid = 0;
  endtask

  task automatic rd(logic [2:0] a, output logic [7:0] v);
    cmd(2'b00, a, 8'h00);
    v = rd_data;
  endtask

  task automatic idle_cyc(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic stat_read(string req, logic dq7, logic to);
    logic [7:0] v;
    rd(3'd0, v);
    check(req, v, {dq7, exp_tog, to, 5'b0});
    exp_tog = ~exp_tog;
  endtask

  task automatic t_reset_state();
    logic [7:0] v;
    check("R6 busy after reset", {7'b0, busy}, 8'h00);
    rd(3'd3, v); check("R1 erased word after reset", v, 8'hFF);
    rd(3'd7, v); check("R8 idle read top address", v, 8'hFF);
  endtask

  task automatic t_legal_program();
    logic [7:0] v;
    cmd(2'b01, 3'd3, 8'hA5); exp_tog = 1;
    check("R2 busy during program", {7'b0, busy}, 8'h01);
    stat_read("R3 status first read", 1'b0, 1'b0);
    stat_read("R4 status second read", 1'b0, 1'b0);
    idle_cyc(PC);
    check("R2 busy drops", {7'b0, busy}, 8'h00);
    rd(3'd3, v); check("R2 programmed word", v, 8'hA5);
    cmd(2'b01, 3'd3, 8'h21); idle_cyc(PC + 1);
    rd(3'd3, v); check("R2 AND into stored word", v, 8'h21);
  endtask

  task automatic t_busy_ignored();
    logic [7:0] v;
    cmd(2'b01, 3'd5, 8'h84);
    cmd(2'b10, 3'd0, 8'h00);
    cmd(2'b01, 3'd6, 8'h00);
    idle_cyc(PC + 2);
    rd(3'd5, v); check("R7 first program kept", v, 8'h84);
    rd(3'd6, v); check("R7 program while busy ignored", v, 8'hFF);
    rd(3'd3, v); check("R7 erase while busy ignored", v, 8'h21);
  endtask

  task automatic t_doomed_program();
    logic [7:0] v;
    cmd(2'b01, 3'd3, 8'h23); exp_tog = 1;
    stat_read("R5 status before timeout a", 1'b1, 1'b0);
    stat_read("R5 status before timeout b", 1'b1, 1'b0);
    idle_cyc(20);
    stat_read("R5 no early timeout", 1'b1, 1'b0);
    idle_cyc(TC);
    stat_read("R5 timeout set", 1'b1, 1'b1);
    stat_read("R4 toggle after timeout", 1'b1, 1'b1);
    check("R5 still busy", {7'b0, busy}, 8'h01);
    cmd(2'b01, 3'd6, 8'h00);
    stat_read("R7 program ignored in fail", 1'b1, 1'b1);
    cmd(2'b11, 3'd0, 8'h00);
    check("R6 reset leaves busy", {7'b0, busy}, 8'h00);
    rd(3'd3, v); check("R5 word unchanged", v, 8'h21);
    rd(3'd6, v); check("R7 fail-state program ignored", v, 8'hFF);
  endtask

  task automatic t_erase();
    logic [7:0] v;
    cmd(2'b10, 3'd0, 8'h00); exp_tog = 1;
    stat_read("R3 erase status", 1'b0, 1'b0);
    idle_cyc(EC - 3);
    check("R1 busy during erase", {7'b0, busy}, 8'h01);
    idle_cyc(3);
    check("R1 erase done", {7'b0, busy}, 8'h00);
    rd(3'd3, v); check("R1 erased word 3", v, 8'hFF);
    rd(3'd5, v); check("R1 erased word 5", v, 8'hFF);
  endtask

  task automatic t_abort_program();
    logic [7:0] v;
    cmd(2'b01, 3'd0, 8'h00);
    cmd(2'b11, 3'd0, 8'h00);
    check("R6 abort busy low", {7'b0, busy}, 8'h00);
    idle_cyc(PC + 2);
    rd(3'd0, v); check("R6 aborted word unchanged", v, 8'hFF);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset_state();
    t_legal_program();
    t_busy_ignored();
    t_doomed_program();
    t_erase();
    t_abort_program();
    summary();
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
  end
endmodule